// File: doc/BRIEF.md
# Power-Switch Dimming Level Sequencer

This block picks an LED current level from the way a user works the ordinary wall switch that feeds the lamp. It watches a digital supply-present signal. When the supply drops and comes back quickly, the block treats that as a request to dim and moves to the next level of a cyclic sequence. When the supply stays away for longer than the window (about two seconds in silicon), the next power-up starts again at full current.

Two static selection pins choose the sequence. A pin that is left open reads as 1 and a pin tied to ground reads as 0. The output is a 2-bit level index and a 7-bit percentage, which the current-threshold logic that follows can use. Both outputs change only in the cycle after a debounced power-restored edge is seen.

Top module: `swdim_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `level_idx` is 0 and `level_pct` is 100.
- R2: If the supply is restored after an outage of at most `WINDOW_CYCLES` debounced cycles, the level advances one step in the selected sequence.
- R3: If the supply is restored after an outage longer than `WINDOW_CYCLES` cycles, the level returns to index 0 (100%).
- R4: With `seq_open_a`=1 and `seq_open_b`=1, every restore gives index 0 and 100%.
- R5: With `seq_open_a`=1 and `seq_open_b`=0, the sequence is index 0 = 100%, then index 1 = 30%.
- R6: With `seq_open_a`=0 and `seq_open_b`=1, the sequence is index 0 = 100%, then index 1 = 50%.
- R7: With `seq_open_a`=0 and `seq_open_b`=0, the sequence is index 0 = 100%, then index 1 = 50%, then index 2 = 20%.
- R8: A dimming action taken at the last level of a sequence wraps back to index 0. Index 3 never appears.
- R9: A low pulse on `supply_ok_raw` that is shorter than `HOLD_CYCLES` cycles is ignored and leaves the level unchanged.
- R10: The outputs stay constant in every cycle that does not follow a debounced restore edge.
- R11: The first restore after reset gives index 0 (100%), whatever the length of the outage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| supply_ok_raw | input | 1 | Asynchronous supply-present indication, 1 when powered |
| seq_open_a | input | 1 | First sequence select pin, 1 when open |
| seq_open_b | input | 1 | Second sequence select pin, 1 when open |
| level_idx | output | 2 | Current position in the dimming sequence |
| level_pct | output | 7 | Current level as a percentage of full current |

## Verification
The bench runs all four pin settings. For each setting it applies a train of short outages, which shows whether the sequence order and its wrap point are right for that setting. Outages just below and just above the window separate a dimming action from a normal power cycle at the threshold. A long outage taken at a non-zero level shows the return to full current. Low pulses shorter than the debounce hold time show that switch bounce does not count as a dimming action.

// File: rtl/swdim_pkg.sv
package swdim_pkg;

    typedef enum logic [1:0] {
        SEQ_FIXED = 2'd0,
        SEQ_ALT30 = 2'd1,
        SEQ_ALT50 = 2'd2,
        SEQ_TRI   = 2'd3
    } seq_mode_e;

    typedef logic [1:0] lvl_idx_t;
    typedef logic [6:0] pct_t;

    typedef struct packed {
        lvl_idx_t idx;
        pct_t     pct;
    } level_s;

    localparam pct_t PCT_FULL = 7'd100;

    function automatic seq_mode_e decode_mode(input logic open_a, input logic open_b);
        case ({open_a, open_b})
            2'b11:   return SEQ_FIXED;
            2'b10:   return SEQ_ALT30;
            2'b01:   return SEQ_ALT50;
            default: return SEQ_TRI;
        endcase
    endfunction

    function automatic logic [2:0] seq_len(input seq_mode_e m);
        case (m)
            SEQ_FIXED: return 3'd1;
            SEQ_ALT30: return 3'd2;
            SEQ_ALT50: return 3'd2;
            default:   return 3'd3;
        endcase
    endfunction

    function automatic pct_t step_pct(input seq_mode_e m, input lvl_idx_t idx);
        case (idx)
            2'd1:    return (m == SEQ_ALT30) ? 7'd30 : 7'd50;
            2'd2:    return 7'd20;
            default: return PCT_FULL;
        endcase
    endfunction

    function automatic lvl_idx_t next_idx(input seq_mode_e m, input lvl_idx_t idx);
        logic [2:0] nxt;
        nxt = {1'b0, idx} + 3'd1;
        if (nxt >= seq_len(m)) return 2'd0;
        return nxt[1:0];
    endfunction

endpackage

// File: rtl/swdim_debounce.sv
module swdim_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          hold_cnt;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt     <= 1'b0;
            hold_cnt <= '0;
        end else if (sync_out == filt) begin
            hold_cnt <= '0;
        end else if (hold_cnt == CW'(HOLD_CYCLES - 1)) begin
            filt     <= sync_out;
            hold_cnt <= '0;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swdim_gap_timer.sv
module swdim_gap_timer #(
    parameter int WINDOW_CYCLES = 200_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fall,
    input  logic pwr_level,
    output logic long_gap
);
    localparam int TW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [TW-1:0] LIMIT = TW'(WINDOW_CYCLES);

    logic [TW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= LIMIT;
        end else if (pwr_fall) begin
            gap_cnt <= '0;
        end else if (!pwr_level && gap_cnt != LIMIT) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign long_gap = (gap_cnt == LIMIT);
endmodule

// File: rtl/swdim_level_seq.sv
module swdim_level_seq
    import swdim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restore,
    input  logic      long_gap,
    input  seq_mode_e mode,
    output level_s    lvl
);
    lvl_idx_t nxt;

    always_comb begin
        if (long_gap || mode == SEQ_FIXED) nxt = 2'd0;
        else                               nxt = next_idx(mode, lvl.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl.idx <= 2'd0;
            lvl.pct <= PCT_FULL;
        end else if (restore) begin
            lvl.idx <= nxt;
            lvl.pct <= step_pct(mode, nxt);
        end
    end
endmodule

// File: rtl/swdim_top.sv
module swdim_top
    import swdim_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int HOLD_CYCLES   = 4,
    parameter int WINDOW_CYCLES = 200_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_raw,
    input  logic       seq_open_a,
    input  logic       seq_open_b,
    output logic [1:0] level_idx,
    output logic [6:0] level_pct
);
    logic      pwr_filt;
    logic      pwr_filt_q;
    logic      pwr_rise;
    logic      pwr_fall;
    logic      gap_long;
    seq_mode_e mode;
    level_s    lvl;

    swdim_debounce #(
        .SYNC_STAGES(SYNC_STAGES),
        .HOLD_CYCLES(HOLD_CYCLES)
    ) deb_i (
        .clk (clk),
        .rst (rst),
        .raw (supply_ok_raw),
        .filt(pwr_filt)
    );

    always_ff @(posedge clk) begin
        if (rst) pwr_filt_q <= 1'b0;
        else     pwr_filt_q <= pwr_filt;
    end

    assign pwr_rise = pwr_filt & ~pwr_filt_q;
    assign pwr_fall = ~pwr_filt & pwr_filt_q;
    assign mode     = decode_mode(seq_open_a, seq_open_b);

    swdim_gap_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) gap_i (
        .clk      (clk),
        .rst      (rst),
        .pwr_fall (pwr_fall),
        .pwr_level(pwr_filt),
        .long_gap (gap_long)
    );

    swdim_level_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .restore (pwr_rise),
        .long_gap(gap_long),
        .mode    (mode),
        .lvl     (lvl)
    );

    assign level_idx = lvl.idx;
    assign level_pct = lvl.pct;
endmodule

// File: rtl/swdim_checker.sv
module swdim_checker (
    input logic       clk,
    input logic       rst,
    input logic       rise,
    input logic       long_gap,
    input logic       sel_a,
    input logic       sel_b,
    input logic [1:0] idx,
    input logic [6:0] pct
);
    AST_RESET_FULL: assert property (@(posedge clk) rst |=> (idx == 2'd0 && pct == 7'd100)); // R1
    AST_SHORT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (rise && !long_gap && !sel_a && !sel_b && idx == 2'd0) |=> (idx == 2'd1 && pct == 7'd50)); // R2
    AST_LONG_RESTART: assert property (@(posedge clk) disable iff (rst)
        (rise && long_gap) |=> (idx == 2'd0 && pct == 7'd100)); // R3
    AST_FIXED_FULL: assert property (@(posedge clk) disable iff (rst)
        (rise && sel_a && sel_b) |=> (idx == 2'd0)); // R4
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst) idx != 2'd3); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(idx) && $stable(pct))); // R10
endmodule

bind swdim_top swdim_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .rise    (pwr_rise),
    .long_gap(gap_long),
    .sel_a   (seq_open_a),
    .sel_b   (seq_open_b),
    .idx     (level_idx),
    .pct     (level_pct)
);

// File: tb/swdim_top_tb_top.sv
module swdim_top_tb_top;
    localparam int HOLD = 3;
    localparam int WIN  = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw = 1'b0;
    logic       sel_a = 1'b1;
    logic       sel_b = 1'b1;
    logic [1:0] level_idx;
    logic [6:0] level_pct;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    swdim_top #(
        .SYNC_STAGES(2),
        .HOLD_CYCLES(HOLD),
        .WINDOW_CYCLES(WIN)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .supply_ok_raw(raw),
        .seq_open_a   (sel_a),
        .seq_open_b   (sel_b),
        .level_idx    (level_idx),
        .level_pct    (level_pct)
    );

    function automatic int exp_pct(input bit a, input bit b, input int k);
        if (k == 0) return 100;
        if (k == 1) return (a && !b) ? 30 : 50;
        return 20;
    endfunction

    task automatic chk(input string req, input int ei, input int ep);
        vectors++;
        if (int'(level_idx) != ei || int'(level_pct) != ep) begin
            errors++;
            $display("FAIL %s: idx=%0d pct=%0d expected idx=%0d pct=%0d",
                     req, level_idx, level_pct, ei, ep);
        end
    endtask

    task automatic outage(input int n);
        @(negedge clk) raw = 1'b0;
        repeat (n) @(negedge clk);
        raw = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int m = 3; m >= 0; m--) begin
            bit a, b;
            int len, e;
            string rq;
            a = m[1];
            b = m[0];
            len = (a && b) ? 1 : ((a || b) ? 2 : 3);
            rq = (a && b) ? "R4" : (a ? "R5" : (b ? "R6" : "R7"));
            @(negedge clk);
            sel_a = a; sel_b = b; raw = 1'b0; rst = 1'b1;
            repeat (3) @(negedge clk);
            chk("R1 in reset", 0, 100);
            rst = 1'b0;
            @(negedge clk);
            chk("R1 after reset", 0, 100);
            // first power-up after reset, short wait: still full current (R11)
            repeat (5) @(negedge clk);
            raw = 1'b1;
            repeat (12) @(negedge clk);
            chk("R11", 0, 100);
            e = 0;
            for (int k = 0; k < 5; k++) begin
                outage(10);
                e = (e + 1) % len;
                chk((e == 0 && len > 1) ? "R8 wrap" : rq, e, exp_pct(a, b, e));
            end
            outage(WIN - 3);
            e = (e + 1) % len;
            chk("R2 near window", e, exp_pct(a, b, e));
            @(negedge clk) raw = 1'b0;
            repeat (HOLD - 1) @(negedge clk);
            raw = 1'b1;
            repeat (12) @(negedge clk);
            chk("R9 glitch", e, exp_pct(a, b, e));
            outage(WIN + 3);
            e = 0;
            chk("R3 just over window", 0, 100);
            if (len > 1) begin
                outage(10);
                chk("R2 step", 1, exp_pct(a, b, 1));
                outage(60);
                chk("R3 long outage", 0, 100);
            end
            // steady power: no change (R10)
            repeat (100) @(negedge clk);
            chk("R10 steady", 0, 100);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule